// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block takes configuration writes from a three-wire serial link and turns each one into a write to a parallel register bank. The three wires are an enable, a serial clock and a data line. The block runs on the serial clock itself. On every rising edge of that clock while the enable is high, it samples one bit.

A frame is 40 bits long. It carries an 8-bit register address followed by a 32-bit data word, each sent most significant bit first. The write is committed on the first rising clock edge at which the enable is seen low again, which is the extra clock pulse the sender supplies after dropping the enable. If a frame has any length other than exactly 40 bits, it is thrown away. An address that names no register is also thrown away.

The bank holds ten 32-bit registers, and all of them are exposed as one packed output:

- Indices 0 to 3 are the input-channel frequency words.
- Indices 4 to 7 are the output-channel frequency words.
- Index 8 is the rate word.
- Index 9 is the miscellaneous word.

Each accepted write also produces a one-cycle strobe, presented together with the address that was written.

Top module: `sercfg_rx`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register in the bank clears to zero and `wrStrobe` goes to 0.
- R2: Bits are sampled on rising `serClk` edges while `serEn` is high. The first 8 bits form the address and the next 32 bits form the data, each most significant bit first. When the first edge with `serEn` low follows exactly 40 sampled bits, `regBank[addr]` takes the data at that edge.
- R3: Address values 0 to 9 map one-to-one onto `regBank` indices 0 to 9. The bits of index k sit at `regBank[32*k+31 : 32*k]`. Indices 0 to 3 are the input frequency words, 4 to 7 the output frequency words, 8 the rate word and 9 the miscellaneous word.
- R4: A complete frame whose address is 10 or above changes no register and raises no strobe.
- R5: A frame of fewer than 40 bits changes no register and raises no strobe.
- R6: A frame of more than 40 bits changes no register and raises no strobe.
- R7: Each accepted write sets `wrStrobe` high for exactly one cycle, starting at the commit edge. During that cycle, `wrAddr` equals the written address.
- R8: Each rise of `serEn` restarts the bit count and the shift register. A full frame sent after an aborted partial frame therefore writes exactly its own address and data.
- R9: An accepted write leaves every register other than the addressed one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Serial clock. Bits are sampled on its rising edge. |
| rst | input | 1 | Active-high synchronous reset. |
| serEn | input | 1 | Frame enable. A frame lasts while this is high. |
| serData | input | 1 | Serial data, most significant bit first. |
| regBank | output | 320 | Ten 32-bit registers. Index k is at bits 32k+31 to 32k. |
| wrStrobe | output | 1 | One-cycle pulse for each accepted write. |
| wrAddr | output | 8 | Address of the write, valid while `wrStrobe` is high. |

## Verification
The bench sweeps every address from 0 to 15 and compares the whole bank after each frame. It does this because a design that decoded the address wrongly would write a neighbouring register or accept an address that names no register. A walking one through the data field exposes a reversed or shifted bit order, which would put the one at the wrong position. Frames of 1, 8, 39, 41 and 47 bits check that frames of the wrong length are dropped; a design with a loose length check would commit truncated or shifted data. A partial frame followed immediately by a full one catches a shift register that is not restarted, which would leak stale bits into the next write.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  // Strobes the control unit sends to the datapath on each serial clock edge.
  typedef struct packed {
    logic loadFirst;  // the enable has just risen: restart the shift register with this bit
    logic shiftIn;    // the frame continues: append this bit
    logic commit;     // the enable has fallen after exactly one full frame
  } ctrlStrobes_t;
endpackage

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         serEn,
  output ctrlStrobes_t ctrl
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

  logic             enPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             enRise;
  logic             enFall;

  assign enRise = serEn & ~enPrev;
  assign enFall = ~serEn & enPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      enPrev <= 1'b0;
      bitCnt <= '0;
    end else begin
      enPrev <= serEn;
      if (enRise) begin
        bitCnt <= CNT_W'(1);
      end else if (serEn && bitCnt != CNT_OVER) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctrl.loadFirst = enRise;
    ctrl.shiftIn   = serEn & ~enRise;
    ctrl.commit    = enFall && (bitCnt == CNT_FULL);
  end

  // R8: a rising enable restarts the count at one bit
  a_r8_count_restart: assert property (@(posedge clk) disable iff (rst)
    (serEn && !enPrev) |=> (bitCnt == CNT_W'(1)));

  // R6: the count saturates just past a full frame
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CNT_OVER);

  // R5: no commit can follow a cycle in which the enable was low
  a_r5_commit_after_frame: assert property (@(posedge clk) disable iff (rst)
    !serEn |=> !ctrl.commit);
endmodule

// File: rtl/sercfg_datapath.sv
module sercfg_datapath
  import sercfg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             serData,
  input  ctrlStrobes_t                     ctrl,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regBank,
  output logic                             wrStrobe,
  output logic [ADDR_W-1:0]                wrAddr
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;

  logic [FRAME_LEN-1:0] shiftReg;
  logic [ADDR_W-1:0]    frmAddr;
  logic [DATA_W-1:0]    frmData;
  logic                 addrOk;

  assign frmAddr = shiftReg[FRAME_LEN-1:DATA_W];
  assign frmData = shiftReg[DATA_W-1:0];
  assign addrOk  = (frmAddr < ADDR_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (ctrl.loadFirst) begin
      shiftReg <= {{(FRAME_LEN-1){1'b0}}, serData};
    end else if (ctrl.shiftIn) begin
      shiftReg <= {shiftReg[FRAME_LEN-2:0], serData};
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regBank[i] <= '0;
      end else if (ctrl.commit && addrOk && frmAddr == ADDR_W'(i)) begin
        regBank[i] <= frmData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
    end else begin
      wrStrobe <= ctrl.commit && addrOk;
      if (ctrl.commit) wrAddr <= frmAddr;
    end
  end

  // R4: a commit to an address outside the bank writes nothing
  a_r4_bad_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrl.commit && !addrOk) |=> ($stable(regBank) && !wrStrobe));

  // R9: without a commit the bank holds its value
  a_r9_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
    !ctrl.commit |=> $stable(regBank));

  // R7: a strobe always traces back to a commit
  a_r7_strobe_from_commit: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |-> $past(ctrl.commit));
endmodule

// File: rtl/sercfg_rx.sv
module sercfg_rx
  import sercfg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 10
) (
  input  logic                                serClk,
  input  logic                                rst,
  input  logic                                serEn,
  input  logic                                serData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]     regBank,
  output logic                                wrStrobe,
  output logic [ADDR_W-1:0]                   wrAddr
);
  ctrlStrobes_t ctrl;

  sercfg_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk  (serClk),
    .rst  (rst),
    .serEn(serEn),
    .ctrl (ctrl)
  );

  sercfg_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk     (serClk),
    .rst     (rst),
    .serData (serData),
    .ctrl    (ctrl),
    .regBank (regBank),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr)
  );

  // R7: the write strobe never lasts two cycles
  a_r7_strobe_single: assert property (@(posedge serClk) disable iff (rst)
    wrStrobe |=> !wrStrobe);

  // R1: reset clears the strobe on the next edge
  a_r1_reset_clears: assert property (@(posedge serClk)
    rst |=> (!wrStrobe && regBank == '0));
endmodule

// File: tb/sercfg_rx_test.sv
module sercfg_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serEn = 1'b0;
  logic serData = 1'b0;
  logic [NREG-1:0][31:0] regBank;
  logic wrStrobe;
  logic [7:0] wrAddr;

  logic [31:0] model [NREG];
  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_rx uut (
    .serClk  (clk),
    .rst     (rst),
    .serEn   (serEn),
    .serData (serData),
    .regBank (regBank),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBank(input string req);
    for (int r = 0; r < NREG; r++)
      chk(regBank[r] === model[r], req, regBank[r], model[r]);
  endtask

  // Drives nbits bits (zeros past bit 40), then drops enable; returns at the negedge before the commit edge.
  task automatic sendFrame(input logic [7:0] a, input logic [31:0] d, input int nbits);
    logic [39:0] f;
    f = {a, d};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      serEn = 1'b1;
      serData = (i < 40) ? f[39-i] : 1'b0;
    end
    @(negedge clk);
    serEn = 1'b0;
    serData = 1'b0;
  endtask

  // Checks the cycle after the commit edge, then the following cycle.
  task automatic expectResult(input bit wrote, input logic [7:0] a, input string req);
    @(negedge clk);
    chk(wrStrobe === wrote, {req, " R7 strobe"}, {31'b0, wrStrobe}, {31'b0, wrote});
    if (wrote) chk(wrAddr === a, "R7 wrAddr", {24'b0, wrAddr}, {24'b0, a});
    chkBank(req);
    @(negedge clk);
    chk(wrStrobe === 1'b0, "R7 strobe single cycle", {31'b0, wrStrobe}, 32'b0);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d, input string req);
    sendFrame(a, d, 40);
    if (a < NREG) model[a] = d;
    expectResult(a < NREG, a, req);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    chkBank("R1 reset");
    chk(wrStrobe === 1'b0, "R1 strobe", {31'b0, wrStrobe}, 32'b0);
    rst = 1'b0;
    @(negedge clk);

    // R3 and R4: sweep addresses 0 to 15; R9: the full bank is compared each time
    for (int a = 0; a < 16; a++)
      writeReg(8'(a), (32'h9E3779B9 * (a + 1)) ^ 32'(a), (a < NREG) ? "R3 map R9" : "R4 bad addr");
    writeReg(8'hFF, 32'hDEADBEEF, "R4 addr 255");
    writeReg(8'h80, 32'h12345678, "R4 addr 128");

    // R2: walking one through the data field checks bit order
    for (int b = 0; b < 32; b++)
      writeReg(8'(b % NREG), 32'h1 << b, "R2 walk one");
    writeReg(8'd9, 32'hFFFFFFFF, "R2 all ones");
    writeReg(8'd0, 32'h0, "R2 all zeros");

    // R5: short frames are dropped
    sendFrame(8'd1, 32'hAAAA5555, 39); expectResult(1'b0, 8'd1, "R5 short 39");
    sendFrame(8'd2, 32'hAAAA5555, 8);  expectResult(1'b0, 8'd2, "R5 short 8");
    sendFrame(8'd3, 32'hAAAA5555, 1);  expectResult(1'b0, 8'd3, "R5 short 1");

    // R6: long frames are dropped
    sendFrame(8'd4, 32'h0F0F0F0F, 41); expectResult(1'b0, 8'd4, "R6 long 41");
    sendFrame(8'd5, 32'h0F0F0F0F, 47); expectResult(1'b0, 8'd5, "R6 long 47");

    // R8: partial frame of ones, then a clean full frame
    sendFrame(8'hFF, 32'hFFFFFFFF, 20);
    writeReg(8'd6, 32'h00C0FFEE, "R8 restart");
    sendFrame(8'hFF, 32'hFFFFFFFF, 39);
    writeReg(8'd7, 32'h00000001, "R8 restart after 39");

    // R1: reset after traffic clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    chkBank("R1 reset after writes");
    chk(wrStrobe === 1'b0, "R1 strobe after reset", {31'b0, wrStrobe}, 32'b0);
    writeReg(8'd8, 32'h87654321, "R2 after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule